// File: doc/BRIEF.md
# Compare-and-Branch Fusion Dispatch Unit

This block sits in the dispatch stage of an out-of-order integer pipeline. Each cycle it receives a group of decoded operations in program order. Wherever a compare or bit-test is followed directly by a conditional jump, it merges the two into one fused branch operation, so the pair takes one scheduler entry and one execution slot. Decode may produce the two halves as separate operations. The merge is done here, on the dispatch side.

A compare whose address comes from base or index registers is never merged. A compare that is the last operation of a group might still pair with a jump that has not arrived yet. Such a compare is kept in a one-entry holding register and placed at the front of the next group, so the pair is judged as a whole. The compacted output group also carries a per-slot grant that says which fused branches may issue this cycle. Up to two fused branches may issue when both are predicted not taken. A fused branch predicted taken allows only one fused branch in that cycle.

Top module: `fuse_dispatch`

## Requirements
- R1: Only an operation of class CMP (code 1) or TEST (code 2) can lead a fused pair. ALU (code 0), JCC (code 3) and OTHER (code 5) operations always pass through unfused. Input valid bits form a prefix starting at slot 0.
- R2: The second half must be a JCC (code 3) in the very next valid position of the stream. A compare followed by anything else is emitted unfused.
- R3: A compare using address mode BASED (code 2) is never fused. Address modes NONE (code 0) and PC-relative (code 1) may fuse.
- R4: A fused output has class FUSED (code 4). It takes its address mode and source operand from the compare, and its condition code, target and predicted-taken bit from the jump.
- R5: The output keeps program order. A fused pair takes one slot, and the valid outputs are packed from slot 0 with no gaps.
- R6: A fusable compare that is the last operation of the stream is held, not emitted. In the next cycle it leads that cycle's stream. It fuses if the first new operation is a JCC, and otherwise it is emitted unfused.
- R7: Pairing scans oldest-first and greedily, and each operation belongs to at most one fused pair.
- R8: Fused branches are granted issue oldest-first and at most two per cycle. A second grant requires both branches to be predicted not taken. Granting stops at the first fused branch that is refused.
- R9: The output group is IN_SLOTS+1 wide, and that width may not exceed the integer dispatch limit (6). The limit is checked at elaboration.
- R10: After reset no compare is held. A cycle with no valid input then produces no valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | IN_SLOTS | Valid bit per input slot (prefix) |
| in_cls | input | 3*IN_SLOTS | Operation class per slot |
| in_am | input | 2*IN_SLOTS | Address mode per slot |
| in_src | input | SRC_W*IN_SLOTS | Source operand field per slot |
| in_cc | input | 4*IN_SLOTS | Condition code per slot |
| in_tgt | input | TGT_W*IN_SLOTS | Branch target per slot |
| in_ptk | input | IN_SLOTS | Predicted-taken per slot |
| out_vld | output | IN_SLOTS+1 | Valid bit per output slot |
| out_cls | output | 3*(IN_SLOTS+1) | Output class |
| out_am | output | 2*(IN_SLOTS+1) | Output address mode |
| out_src | output | SRC_W*(IN_SLOTS+1) | Output source operand |
| out_cc | output | 4*(IN_SLOTS+1) | Output condition code |
| out_tgt | output | TGT_W*(IN_SLOTS+1) | Output branch target |
| out_ptk | output | IN_SLOTS+1 | Output predicted-taken |
| out_br_go | output | IN_SLOTS+1 | Issue grant per fused branch slot |

## Verification
The bench uses IN_SLOTS=4 with 8-bit operand and target fields, which gives a five-slot combined stream. It sweeps every sequence of ALU/CMP/TEST/JCC classes over every group length from 0 to 4, under three rotations of address mode and varied predicted-taken bits. This covers pairs split across group boundaries, chains of holds across empty groups, and every mix of taken and not-taken fused branches for the grant limit. A small reference model in the bench walks each stream and predicts the output. Directed groups with literal expected values cover reset, field merging and the based-address exclusion.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   localparam int CLS_W = 3;
   localparam int AM_W  = 2;
   localparam int CC_W  = 4;

   localparam logic [CLS_W-1:0] CLS_ALU   = 3'd0;
   localparam logic [CLS_W-1:0] CLS_CMP   = 3'd1;
   localparam logic [CLS_W-1:0] CLS_TEST  = 3'd2;
   localparam logic [CLS_W-1:0] CLS_JCC   = 3'd3;
   localparam logic [CLS_W-1:0] CLS_FUSED = 3'd4;
   localparam logic [CLS_W-1:0] CLS_OTHER = 3'd5;

   localparam logic [AM_W-1:0] AM_NONE  = 2'd0;
   localparam logic [AM_W-1:0] AM_PCREL = 2'd1;
   localparam logic [AM_W-1:0] AM_BASED = 2'd2;

   // a compare/test that may lead a fused pair
   function automatic logic can_lead(input logic [CLS_W-1:0] c, input logic [AM_W-1:0] m);
      return ((c == CLS_CMP) || (c == CLS_TEST)) && (m != AM_BASED);
   endfunction
endpackage

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
   import fuse_pkg::*;
#(
   parameter int S = 5
) (
   input  logic [S-1:0]      vld,
   input  logic [CLS_W-1:0]  cls [S],
   input  logic [AM_W-1:0]   am  [S],
   output logic [S-1:0]      lead,
   output logic [S-1:0]      pair
);
   genvar g;
   generate
      for (g = 0; g < S; g++) begin : g_slot
         assign lead[g] = vld[g] & can_lead(cls[g], am[g]);
         if (g < S-1) begin : g_nb
            assign pair[g] = lead[g] & vld[g+1] & (cls[g+1] == CLS_JCC);
         end else begin : g_end
            assign pair[g] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/fuse_select.sv
module fuse_select #(
   parameter int S  = 5,
   localparam int IW = (S > 1) ? $clog2(S) : 1
) (
   input  logic [S-1:0]  vld,
   input  logic [S-1:0]  lead,
   input  logic [S-1:0]  pair,
   output logic [S-1:0]  start,
   output logic [S-1:0]  emit,
   output logic          hold,
   output logic [IW-1:0] hold_idx
);
   logic [S-1:0] taken_as_jmp;
   logic         prev;
   logic         any;

   always_comb begin
      prev     = 1'b0;
      any      = 1'b0;
      hold_idx = '0;
      for (int i = 0; i < S; i++) begin
         start[i]        = pair[i] & ~prev;
         taken_as_jmp[i] = prev;
         prev            = start[i];
         if (vld[i] && ((i == S-1) || !vld[(i < S-1) ? i+1 : i])) begin
            hold_idx = IW'(i);
            any      = 1'b1;
         end
      end
      hold = any & lead[hold_idx] & ~taken_as_jmp[hold_idx];
      for (int i = 0; i < S; i++) begin
         emit[i] = vld[i] & ~taken_as_jmp[i] & ~(hold && (IW'(i) == hold_idx));
      end
   end
endmodule

// File: rtl/fuse_pack.sv
module fuse_pack
   import fuse_pkg::*;
#(
   parameter int S     = 5,
   parameter int SRC_W = 8,
   parameter int TGT_W = 8
) (
   input  logic [S-1:0]      emit,
   input  logic [S-1:0]      start,
   input  logic [CLS_W-1:0]  cls [S],
   input  logic [AM_W-1:0]   am  [S],
   input  logic [SRC_W-1:0]  src [S],
   input  logic [CC_W-1:0]   cc  [S],
   input  logic [TGT_W-1:0]  tgt [S],
   input  logic [S-1:0]      ptk,
   output logic [S-1:0]      o_vld,
   output logic [CLS_W-1:0]  o_cls [S],
   output logic [AM_W-1:0]   o_am  [S],
   output logic [SRC_W-1:0]  o_src [S],
   output logic [CC_W-1:0]   o_cc  [S],
   output logic [TGT_W-1:0]  o_tgt [S],
   output logic [S-1:0]      o_ptk
);
   int pos;
   int nx;

   always_comb begin
      pos   = 0;
      nx    = 0;
      o_vld = '0;
      o_ptk = '0;
      for (int k = 0; k < S; k++) begin
         o_cls[k] = '0;
         o_am[k]  = '0;
         o_src[k] = '0;
         o_cc[k]  = '0;
         o_tgt[k] = '0;
      end
      for (int i = 0; i < S; i++) begin
         nx = (i < S-1) ? i+1 : i;
         if (emit[i]) begin
            o_vld[pos] = 1'b1;
            o_am[pos]  = am[i];
            o_src[pos] = src[i];
            if (start[i]) begin
               o_cls[pos] = CLS_FUSED;
               o_cc[pos]  = cc[nx];
               o_tgt[pos] = tgt[nx];
               o_ptk[pos] = ptk[nx];
            end else begin
               o_cls[pos] = cls[i];
               o_cc[pos]  = cc[i];
               o_tgt[pos] = tgt[i];
               o_ptk[pos] = ptk[i];
            end
            pos = pos + 1;
         end
      end
   end
endmodule

// File: rtl/fuse_br_grant.sv
module fuse_br_grant
   import fuse_pkg::*;
#(
   parameter int S      = 5,
   parameter int NT_MAX = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [S-1:0]      o_vld,
   input  logic [CLS_W-1:0]  o_cls [S],
   input  logic [S-1:0]      o_ptk,
   output logic [S-1:0]      go
);
   logic [S-1:0] is_fb;

   always_comb begin
      for (int i = 0; i < S; i++) is_fb[i] = o_vld[i] && (o_cls[i] == CLS_FUSED);
   end

   generate
      if (NT_MAX == 1) begin : g_single
         always_comb begin
            go = '0;
            for (int i = S-1; i >= 0; i--) begin
               if (is_fb[i]) go = S'(1) << i;
            end
         end
      end else begin : g_multi
         int  granted;
         logic seen_tk;
         logic blocked;
         always_comb begin
            go      = '0;
            granted = 0;
            seen_tk = 1'b0;
            blocked = 1'b0;
            for (int i = 0; i < S; i++) begin
               if (is_fb[i] && !blocked) begin
                  if (granted == 0) begin
                     go[i]   = 1'b1;
                     granted = 1;
                     seen_tk = o_ptk[i];
                  end else if (granted < NT_MAX && !seen_tk && !o_ptk[i]) begin
                     go[i]   = 1'b1;
                     granted = granted + 1;
                  end else begin
                     blocked = 1'b1;
                  end
               end
            end
         end
      end
   endgenerate

   assert_grant_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(go) <= NT_MAX);
   assert_taken_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(go & o_ptk)) |-> ($countones(go) == 1));
endmodule

// File: rtl/fuse_dispatch.sv
module fuse_dispatch
   import fuse_pkg::*;
#(
   parameter int IN_SLOTS     = 4,
   parameter int SRC_W        = 8,
   parameter int TGT_W        = 8,
   parameter int INT_DISP_MAX = 6,
   parameter int NT_BR_MAX    = 2,
   localparam int S  = IN_SLOTS + 1,
   localparam int IW = $clog2(S)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IN_SLOTS-1:0]       in_vld,
   input  logic [CLS_W*IN_SLOTS-1:0] in_cls,
   input  logic [AM_W*IN_SLOTS-1:0]  in_am,
   input  logic [SRC_W*IN_SLOTS-1:0] in_src,
   input  logic [CC_W*IN_SLOTS-1:0]  in_cc,
   input  logic [TGT_W*IN_SLOTS-1:0] in_tgt,
   input  logic [IN_SLOTS-1:0]       in_ptk,
   output logic [S-1:0]              out_vld,
   output logic [CLS_W*S-1:0]        out_cls,
   output logic [AM_W*S-1:0]         out_am,
   output logic [SRC_W*S-1:0]        out_src,
   output logic [CC_W*S-1:0]         out_cc,
   output logic [TGT_W*S-1:0]        out_tgt,
   output logic [S-1:0]              out_ptk,
   output logic [S-1:0]              out_br_go
);
   // elaboration checks (R9)
   generate
      if (IN_SLOTS < 1) begin : g_bad_slots
         $error("IN_SLOTS must be at least 1");
      end
      if (S > INT_DISP_MAX) begin : g_bad_width
         $error("output group wider than integer dispatch limit");
      end
      if (NT_BR_MAX < 1 || NT_BR_MAX > 2) begin : g_bad_nt
         $error("NT_BR_MAX must be 1 or 2");
      end
      if (SRC_W < 1 || TGT_W < 1) begin : g_bad_fields
         $error("field widths must be positive");
      end
   endgenerate

   // held compare waiting for its possible jump
   logic             hv_q;
   logic [CLS_W-1:0] hcls_q;
   logic [AM_W-1:0]  ham_q;
   logic [SRC_W-1:0] hsrc_q;
   logic [CC_W-1:0]  hcc_q;
   logic [TGT_W-1:0] htgt_q;
   logic             hptk_q;

   // combined stream
   logic [S-1:0]     s_vld;
   logic [CLS_W-1:0] s_cls [S];
   logic [AM_W-1:0]  s_am  [S];
   logic [SRC_W-1:0] s_src [S];
   logic [CC_W-1:0]  s_cc  [S];
   logic [TGT_W-1:0] s_tgt [S];
   logic [S-1:0]     s_ptk;

   always_comb begin
      s_vld = '0;
      s_ptk = '0;
      for (int k = 0; k < S; k++) begin
         s_cls[k] = '0; s_am[k] = '0; s_src[k] = '0; s_cc[k] = '0; s_tgt[k] = '0;
      end
      if (hv_q) begin
         s_vld[0] = 1'b1; s_cls[0] = hcls_q; s_am[0] = ham_q; s_src[0] = hsrc_q;
         s_cc[0]  = hcc_q; s_tgt[0] = htgt_q; s_ptk[0] = hptk_q;
      end
      for (int i = 0; i < IN_SLOTS; i++) begin
         if (hv_q) begin
            s_vld[i+1] = in_vld[i];
            s_cls[i+1] = in_cls[i*CLS_W +: CLS_W];
            s_am[i+1]  = in_am[i*AM_W +: AM_W];
            s_src[i+1] = in_src[i*SRC_W +: SRC_W];
            s_cc[i+1]  = in_cc[i*CC_W +: CC_W];
            s_tgt[i+1] = in_tgt[i*TGT_W +: TGT_W];
            s_ptk[i+1] = in_ptk[i];
         end else begin
            s_vld[i] = in_vld[i];
            s_cls[i] = in_cls[i*CLS_W +: CLS_W];
            s_am[i]  = in_am[i*AM_W +: AM_W];
            s_src[i] = in_src[i*SRC_W +: SRC_W];
            s_cc[i]  = in_cc[i*CC_W +: CC_W];
            s_tgt[i] = in_tgt[i*TGT_W +: TGT_W];
            s_ptk[i] = in_ptk[i];
         end
      end
   end

   logic [S-1:0]  lead, pair, start, emit;
   logic          hold;
   logic [IW-1:0] hold_idx;

   fuse_pair_detect #(.S(S)) u_detect (
      .vld(s_vld), .cls(s_cls), .am(s_am), .lead(lead), .pair(pair));

   fuse_select #(.S(S)) u_select (
      .vld(s_vld), .lead(lead), .pair(pair), .start(start), .emit(emit),
      .hold(hold), .hold_idx(hold_idx));

   logic [S-1:0]     p_vld, p_ptk;
   logic [CLS_W-1:0] p_cls [S];
   logic [AM_W-1:0]  p_am  [S];
   logic [SRC_W-1:0] p_src [S];
   logic [CC_W-1:0]  p_cc  [S];
   logic [TGT_W-1:0] p_tgt [S];

   fuse_pack #(.S(S), .SRC_W(SRC_W), .TGT_W(TGT_W)) u_pack (
      .emit(emit), .start(start), .cls(s_cls), .am(s_am), .src(s_src), .cc(s_cc),
      .tgt(s_tgt), .ptk(s_ptk), .o_vld(p_vld), .o_cls(p_cls), .o_am(p_am),
      .o_src(p_src), .o_cc(p_cc), .o_tgt(p_tgt), .o_ptk(p_ptk));

   fuse_br_grant #(.S(S), .NT_MAX(NT_BR_MAX)) u_grant (
      .clk(clk), .rst_n(rst_n), .o_vld(p_vld), .o_cls(p_cls), .o_ptk(p_ptk),
      .go(out_br_go));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hv_q <= 1'b0; hcls_q <= '0; ham_q <= '0; hsrc_q <= '0;
         hcc_q <= '0; htgt_q <= '0; hptk_q <= 1'b0;
      end else begin
         hv_q <= hold;
         if (hold) begin
            hcls_q <= s_cls[hold_idx]; ham_q <= s_am[hold_idx];
            hsrc_q <= s_src[hold_idx]; hcc_q <= s_cc[hold_idx];
            htgt_q <= s_tgt[hold_idx]; hptk_q <= s_ptk[hold_idx];
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < S; g++) begin : g_out
         assign out_cls[g*CLS_W +: CLS_W] = p_cls[g];
         assign out_am[g*AM_W +: AM_W]    = p_am[g];
         assign out_src[g*SRC_W +: SRC_W] = p_src[g];
         assign out_cc[g*CC_W +: CC_W]    = p_cc[g];
         assign out_tgt[g*TGT_W +: TGT_W] = p_tgt[g];
      end
   endgenerate
   assign out_vld = p_vld;
   assign out_ptk = p_ptk;

   assert_held_is_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hv_q |-> can_lead(hcls_q, ham_q));
   assert_split_pair_fused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hv_q && in_vld[0] && (in_cls[CLS_W-1:0] == CLS_JCC)) |->
      (out_vld[0] && (out_cls[CLS_W-1:0] == CLS_FUSED)));
   assert_out_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld & (out_vld + S'(1))) == '0);
   assert_no_based_fuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[0] && out_cls[CLS_W-1:0] == CLS_FUSED) |-> (out_am[AM_W-1:0] != AM_BASED));
endmodule

// File: tb/tb_fuse_dispatch.sv
module tb_fuse_dispatch;
   import fuse_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int S  = N + 1;
   localparam int SW = 8;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [N-1:0]       in_vld = '0;
   logic [CLS_W*N-1:0] in_cls = '0;
   logic [AM_W*N-1:0]  in_am  = '0;
   logic [SW*N-1:0]    in_src = '0;
   logic [CC_W*N-1:0]  in_cc  = '0;
   logic [TW*N-1:0]    in_tgt = '0;
   logic [N-1:0]       in_ptk = '0;
   logic [S-1:0]       out_vld, out_ptk, out_br_go;
   logic [CLS_W*S-1:0] out_cls;
   logic [AM_W*S-1:0]  out_am;
   logic [SW*S-1:0]    out_src;
   logic [CC_W*S-1:0]  out_cc;
   logic [TW*S-1:0]    out_tgt;

   fuse_dispatch #(.IN_SLOTS(N), .SRC_W(SW), .TGT_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cls(in_cls), .in_am(in_am),
      .in_src(in_src), .in_cc(in_cc), .in_tgt(in_tgt), .in_ptk(in_ptk),
      .out_vld(out_vld), .out_cls(out_cls), .out_am(out_am), .out_src(out_src),
      .out_cc(out_cc), .out_tgt(out_tgt), .out_ptk(out_ptk), .out_br_go(out_br_go));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   // model state and expectations
   bit          mh_v;
   logic [2:0]  mh_cls; logic [1:0] mh_am; logic [7:0] mh_src, mh_tgt; logic [3:0] mh_cc; bit mh_pt;
   bit          nh_v;
   logic [2:0]  nh_cls; logic [1:0] nh_am; logic [7:0] nh_src, nh_tgt; logic [3:0] nh_cc; bit nh_pt;
   logic [S-1:0] e_vld, e_ptk, e_go;
   logic [2:0] e_cls [S]; logic [1:0] e_am [S]; logic [7:0] e_src [S];
   logic [3:0] e_cc [S];  logic [7:0] e_tgt [S];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic set_slot(input int i, input logic [2:0] c, input logic [1:0] m,
                           input logic [7:0] s, input logic [3:0] k, input logic [7:0] t, input bit p);
      in_vld[i] = 1'b1;
      in_cls[i*3 +: 3] = c; in_am[i*2 +: 2] = m; in_src[i*8 +: 8] = s;
      in_cc[i*4 +: 4] = k;  in_tgt[i*8 +: 8] = t; in_ptk[i] = p;
   endtask

   task automatic clear_in();
      in_vld = '0; in_cls = '0; in_am = '0; in_src = '0; in_cc = '0; in_tgt = '0; in_ptk = '0;
   endtask

   function automatic bit leads(input logic [2:0] c, input logic [1:0] m);
      return (c == 3'd1 || c == 3'd2) && m != 2'd2;
   endfunction

   // reference: walk the stream of held + new operations
   task automatic model();
      logic [2:0] c [S]; logic [1:0] m [S]; logic [7:0] s [S]; logic [3:0] k [S];
      logic [7:0] t [S]; bit p [S];
      int tot = 0; int i = 0; int o = 0; int ng = 0; bit tk = 0; bit stop = 0;
      if (mh_v) begin
         c[0] = mh_cls; m[0] = mh_am; s[0] = mh_src; k[0] = mh_cc; t[0] = mh_tgt; p[0] = mh_pt; tot = 1;
      end
      for (int j = 0; j < N; j++) if (in_vld[j]) begin
         c[tot] = in_cls[j*3 +: 3]; m[tot] = in_am[j*2 +: 2]; s[tot] = in_src[j*8 +: 8];
         k[tot] = in_cc[j*4 +: 4]; t[tot] = in_tgt[j*8 +: 8]; p[tot] = in_ptk[j]; tot++;
      end
      e_vld = '0; e_ptk = '0; e_go = '0; nh_v = 0;
      for (int j = 0; j < S; j++) begin e_cls[j] = 0; e_am[j] = 0; e_src[j] = 0; e_cc[j] = 0; e_tgt[j] = 0; end
      while (i < tot) begin
         if (leads(c[i], m[i]) && i+1 < tot && c[i+1] == 3'd3) begin
            e_vld[o] = 1; e_cls[o] = 3'd4; e_am[o] = m[i]; e_src[o] = s[i];
            e_cc[o] = k[i+1]; e_tgt[o] = t[i+1]; e_ptk[o] = p[i+1]; o++; i += 2;
         end else if (leads(c[i], m[i]) && i == tot-1) begin
            nh_v = 1; nh_cls = c[i]; nh_am = m[i]; nh_src = s[i]; nh_cc = k[i]; nh_tgt = t[i]; nh_pt = p[i];
            i++;
         end else begin
            e_vld[o] = 1; e_cls[o] = c[i]; e_am[o] = m[i]; e_src[o] = s[i];
            e_cc[o] = k[i]; e_tgt[o] = t[i]; e_ptk[o] = p[i]; o++; i++;
         end
      end
      for (int j = 0; j < S; j++) if (e_vld[j] && e_cls[j] == 3'd4 && !stop) begin
         if (ng == 0) begin e_go[j] = 1; ng = 1; tk = e_ptk[j]; end
         else if (ng == 1 && !tk && !e_ptk[j]) begin e_go[j] = 1; ng = 2; end
         else stop = 1;
      end
   endtask

   task automatic compare(input string tag);
      bit bad = 0;
      checks++;
      for (int j = 0; j < S; j++) begin
         if (out_vld[j] !== e_vld[j] || out_cls[j*3 +: 3] !== e_cls[j] || out_am[j*2 +: 2] !== e_am[j] ||
             out_src[j*8 +: 8] !== e_src[j] || out_cc[j*4 +: 4] !== e_cc[j] ||
             out_tgt[j*8 +: 8] !== e_tgt[j] || out_ptk[j] !== e_ptk[j] || out_br_go[j] !== e_go[j]) begin
            if (!bad)
               $display("FAIL %s slot %0d: actual v%0b c%0d a%0d s%h k%h t%h p%0b g%0b expected v%0b c%0d a%0d s%h k%h t%h p%0b g%0b",
                  tag, j, out_vld[j], out_cls[j*3 +: 3], out_am[j*2 +: 2], out_src[j*8 +: 8], out_cc[j*4 +: 4],
                  out_tgt[j*8 +: 8], out_ptk[j], out_br_go[j], e_vld[j], e_cls[j], e_am[j], e_src[j],
                  e_cc[j], e_tgt[j], e_ptk[j], e_go[j]);
            bad = 1;
         end
      end
      if (bad) errors++;
   endtask

   // inputs already set; check mid-cycle then advance model state
   task automatic step(input string tag);
      #2;
      model();
      compare(tag);
      @(posedge clk); #1;
      mh_v = nh_v; mh_cls = nh_cls; mh_am = nh_am; mh_src = nh_src; mh_cc = nh_cc; mh_tgt = nh_tgt; mh_pt = nh_pt;
      @(negedge clk);
   endtask

   task automatic lit(input string tag, input logic [S-1:0] v, input logic [2:0] c0, input logic [S-1:0] g);
      checks++;
      if (out_vld !== v || out_cls[2:0] !== c0 || out_br_go !== g) begin
         errors++;
         $display("FAIL %s: actual vld %b cls0 %0d go %b expected vld %b cls0 %0d go %b",
                  tag, out_vld, out_cls[2:0], out_br_go, v, c0, g);
      end
   endtask

   initial begin
      mh_v = 0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (out_vld !== '0) begin errors++; $display("FAIL R10 reset: actual %b expected 0", out_vld); end
      rst_n = 1'b1;
      @(negedge clk);

      // R9 width
      checks++;
      if ($bits(out_vld) != N+1 || N+1 > 6) begin
         errors++; $display("FAIL R9 width: actual %0d expected %0d", $bits(out_vld), N+1);
      end

      // R10 empty cycle after reset
      clear_in(); #2; lit("R10 idle", '0, 3'd0, '0); @(negedge clk);

      // R4 fused fields
      clear_in(); set_slot(0, 3'd1, 2'd1, 8'hA5, 4'h0, 8'h00, 0); set_slot(1, 3'd3, 2'd0, 8'h11, 4'h5, 8'h33, 1);
      #2; lit("R4 fuse", 5'b00001, 3'd4, 5'b00001);
      checks++;
      if (out_src[7:0] !== 8'hA5 || out_cc[3:0] !== 4'h5 || out_tgt[7:0] !== 8'h33 || out_ptk[0] !== 1'b1 || out_am[1:0] !== 2'd1) begin
         errors++; $display("FAIL R4 fields: actual s%h k%h t%h p%0b a%0d expected sa5 k5 t33 p1 a1",
                             out_src[7:0], out_cc[3:0], out_tgt[7:0], out_ptk[0], out_am[1:0]);
      end
      @(negedge clk);

      // R3 based-address compare stays apart
      clear_in(); set_slot(0, 3'd1, 2'd2, 8'h01, 4'h0, 8'h0, 0); set_slot(1, 3'd3, 2'd0, 8'h02, 4'h2, 8'h9, 0);
      #2; lit("R3 based", 5'b00011, 3'd1, 5'b00000); @(negedge clk);

      // R1 ALU does not lead
      clear_in(); set_slot(0, 3'd0, 2'd0, 8'h01, 4'h0, 8'h0, 0); set_slot(1, 3'd3, 2'd0, 8'h02, 4'h2, 8'h9, 0);
      #2; lit("R1 alu", 5'b00011, 3'd0, 5'b00000); @(negedge clk);

      // R2 something in between
      clear_in(); set_slot(0, 3'd2, 2'd0, 8'h01, 4'h0, 8'h0, 0); set_slot(1, 3'd0, 2'd0, 8'h02, 4'h0, 8'h0, 0);
      set_slot(2, 3'd3, 2'd0, 8'h03, 4'h1, 8'h7, 0);
      #2; lit("R2 gap", 5'b00111, 3'd2, 5'b00000); @(negedge clk);

      // R6 split pair across groups
      clear_in(); set_slot(0, 3'd0, 2'd0, 8'h01, 4'h0, 8'h0, 0); set_slot(1, 3'd1, 2'd0, 8'h44, 4'h0, 8'h0, 0);
      #2; lit("R6 hold", 5'b00001, 3'd0, 5'b00000); @(negedge clk);
      clear_in(); set_slot(0, 3'd3, 2'd0, 8'h00, 4'h6, 8'h21, 0);
      #2; lit("R6 join", 5'b00001, 3'd4, 5'b00001);
      checks++;
      if (out_src[7:0] !== 8'h44 || out_tgt[7:0] !== 8'h21) begin
         errors++; $display("FAIL R6 join fields: actual s%h t%h expected s44 t21", out_src[7:0], out_tgt[7:0]);
      end
      @(negedge clk);

      // R8 two not-taken grant, taken second refused
      clear_in(); set_slot(0, 3'd1, 2'd0, 8'h1, 4'h1, 8'h0, 0); set_slot(1, 3'd3, 2'd0, 8'h0, 4'h1, 8'h1, 0);
      set_slot(2, 3'd2, 2'd0, 8'h2, 4'h1, 8'h0, 0); set_slot(3, 3'd3, 2'd0, 8'h0, 4'h2, 8'h2, 0);
      #2; lit("R8 two nt", 5'b00011, 3'd4, 5'b00011); @(negedge clk);
      in_ptk[3] = 1'b1;
      #2; lit("R8 taken limit", 5'b00011, 3'd4, 5'b00001); @(negedge clk);

      // sweep: every class sequence, length and address-mode rotation (R2 R5 R6 R7 R8)
      clear_in(); mh_v = 0;
      for (int mv = 0; mv < 3; mv++) begin
         for (int pat = 0; pat < 256; pat++) begin
            for (int n = 0; n <= N; n++) begin
               clear_in();
               for (int i = 0; i < n; i++)
                  set_slot(i, 3'((pat >> (2*i)) & 3), 2'((mv + i) % 3), 8'(pat ^ (i*17)),
                           4'(i + n), 8'(pat + i), bit'(((pat >> i) ^ mv) & 1));
               step("R2 R5 R6 R7 R8 sweep");
            end
         end
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule